// File: doc/BRIEF.md
# Instruction Word Decoder with Constant Generator

This block takes one 16-bit instruction word and turns it into the operand-level facts that a fetch and execute pipeline needs before it touches memory. It sorts the word into one of three layouts: two-operand, one-operand or relative jump. Any other pattern is marked illegal. For each word it extracts the register numbers, the source and destination addressing modes and the byte/word selector, and it reports how many extension words follow the opcode word.

Two source registers have a second job. When register 3 is named as the source, it produces a small constant in every addressing mode. When register 2 is named as the source with an indirect-style mode, it also produces a constant. In both cases the source needs no memory read and no extension word, so the instruction is shorter. The decoder flags this case and supplies the constant value. For the autoincrement source mode it also reports how far the pointer advances.

A word is presented together with `in_valid`. All results appear from a register one clock later and are held until the next valid word arrives.

Top module: `insdec_top`

## Requirements
- R1: `fmt_code` reports the layout of the word. A word whose bits [15:13] are 001 is a jump (11). Otherwise a word whose bits [15:10] are 000100 is a one-operand word (10). Otherwise a word whose bits [15:12] are 4 or more is a two-operand word (01). Every other word is illegal (00).
- R2: For a two-operand word, the outputs take these fields: `src_reg` from bits [11:8], `dst_mode` from bit 7, `byte_op` from bit 6 (1 means byte), `src_mode` from bits [5:4] and `dst_reg` from bits [3:0].
- R3: For a one-operand word, `byte_op` comes from bit 6 and `src_mode` from bits [5:4]. Both `src_reg` and `dst_reg` carry bits [3:0], and `dst_mode` is 0.
- R4: For a jump or illegal word, every register, mode, byte, length, constant, read and increment output is 0.
- R5: Register 3 as the source gives a constant for every source mode: mode 00 gives 0, 01 gives 1, 10 gives 2 and 11 gives all ones (-1). `cg_hit` is 1 and `cg_value` carries the constant. When `cg_hit` is 0, `cg_value` is 0.
- R6: Register 2 as the source gives the constant 4 with mode 10 and 8 with mode 11. With mode 01, register 2 is absolute addressing from base 0, which is not a constant. With mode 00 it is a plain register.
- R7: `ext_words` counts the extension words. The source adds one when its mode is 01 (indexed, symbolic or absolute), or when it is register 0 with mode 11 (immediate), unless `cg_hit` is set. A two-operand word with `dst_mode` 1 adds one more. The total ranges from 0 to 2.
- R8: `post_inc` is nonzero only for source mode 11 without a constant. It is 2 when the source register is 0. Otherwise it is 1 for a byte operation and 2 for a word operation.
- R9: `src_mem_rd` is 1 for a one- or two-operand word whose source mode is not 00 and which takes no constant. A constant-generator source never requests a read.
- R10: Outputs change one clock after `in_valid` is sampled high, and `out_valid` follows `in_valid` with one clock of delay. With `in_valid` low, all decode outputs hold their values. After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word is present this cycle |
| instr_word | input | 16 | Instruction word to decode |
| out_valid | output | 1 | Decode results refer to a word taken last cycle |
| fmt_code | output | 2 | Layout: 00 illegal, 01 two-operand, 10 one-operand, 11 jump |
| src_reg | output | 4 | Source register number |
| dst_reg | output | 4 | Destination register number |
| src_mode | output | 2 | Source addressing mode bits |
| dst_mode | output | 1 | Destination addressing mode bit |
| byte_op | output | 1 | 1 for a byte operation |
| ext_words | output | 2 | Number of extension words that follow |
| cg_hit | output | 1 | Source is a generated constant |
| cg_value | output | 16 | Generated constant |
| src_mem_rd | output | 1 | Source needs a memory read |
| post_inc | output | 2 | Source pointer increment for autoincrement |

## Verification
The bench builds the block with its default parameters: a 16-bit constant width and 4-bit register numbers. At these values all sixteen source registers meet all four source modes, in both byte and word form. That puts every constant-generator code, register 2 in absolute mode, immediate through register 0 and the largest length of two extension words within reach. Directed words cover each of these cases and each layout boundary. After them comes a long pseudo-random stream with gaps in `in_valid`, which exercises the output hold.

// File: rtl/insdec_pkg.sv
package insdec_pkg;
    localparam int INSTR_W   = 16;
    localparam int REG_IDX_W = 4;
    localparam int MODE_W    = 2;
    localparam int EXT_W     = 2;
    localparam int INC_W     = 2;

    localparam logic [REG_IDX_W-1:0] REG_PC    = 4'd0;
    localparam logic [REG_IDX_W-1:0] REG_CONST_A = 4'd2;
    localparam logic [REG_IDX_W-1:0] REG_CONST_B = 4'd3;

    typedef enum logic [1:0] {
        FMT_ILLEGAL = 2'b00,
        FMT_DOUBLE  = 2'b01,
        FMT_SINGLE  = 2'b10,
        FMT_JUMP    = 2'b11
    } fmt_e;

    localparam logic [MODE_W-1:0] SM_REG  = 2'b00;
    localparam logic [MODE_W-1:0] SM_IDX  = 2'b01;
    localparam logic [MODE_W-1:0] SM_IND  = 2'b10;
    localparam logic [MODE_W-1:0] SM_INC  = 2'b11;
endpackage

// File: rtl/insdec_classify.sv
module insdec_classify
    import insdec_pkg::*;
(
    input  logic [INSTR_W-1:0]   instr,
    output fmt_e                 fmt,
    output logic [REG_IDX_W-1:0] s_reg,
    output logic [REG_IDX_W-1:0] d_reg,
    output logic [MODE_W-1:0]    s_mode,
    output logic                 d_mode,
    output logic                 bw
);
    localparam int TOP_JMP_W = 3;
    localparam int TOP_SGL_W = 6;
    localparam logic [TOP_JMP_W-1:0] JMP_PAT = 3'b001;
    localparam logic [TOP_SGL_W-1:0] SGL_PAT = 6'b000100;
    localparam logic [3:0]           DBL_MIN = 4'h4;

    always_comb begin
        if (instr[INSTR_W-1 -: TOP_JMP_W] == JMP_PAT)
            fmt = FMT_JUMP;
        else if (instr[INSTR_W-1 -: TOP_SGL_W] == SGL_PAT)
            fmt = FMT_SINGLE;
        else if (instr[INSTR_W-1 -: 4] >= DBL_MIN)
            fmt = FMT_DOUBLE;
        else
            fmt = FMT_ILLEGAL;
    end

    always_comb begin
        s_reg  = '0;
        d_reg  = '0;
        s_mode = '0;
        d_mode = 1'b0;
        bw     = 1'b0;
        unique case (fmt)
            FMT_DOUBLE: begin
                s_reg  = instr[11:8];
                d_mode = instr[7];
                bw     = instr[6];
                s_mode = instr[5:4];
                d_reg  = instr[3:0];
            end
            FMT_SINGLE: begin
                bw     = instr[6];
                s_mode = instr[5:4];
                s_reg  = instr[3:0];
                d_reg  = instr[3:0];
            end
            FMT_JUMP, FMT_ILLEGAL: begin
                s_reg  = '0;
            end
        endcase
    end
endmodule

// File: rtl/insdec_constgen.sv
module insdec_constgen
    import insdec_pkg::*;
#(
    parameter int WORD_W = INSTR_W
) (
    input  fmt_e                 fmt,
    input  logic [REG_IDX_W-1:0] s_reg,
    input  logic [MODE_W-1:0]    s_mode,
    output logic                 hit,
    output logic [WORD_W-1:0]    value
);
    localparam int N_MODES = 1 << MODE_W;

    logic [WORD_W-1:0] tab_b [N_MODES];
    logic [WORD_W-1:0] tab_a [N_MODES];

    for (genvar m = 0; m < N_MODES; m++) begin : g_tab
        if (m == N_MODES - 1) begin : g_last
            assign tab_b[m] = '1;
        end else begin : g_small
            assign tab_b[m] = WORD_W'(m);
        end
        if (m >= 2) begin : g_pow
            assign tab_a[m] = WORD_W'(4 << (m - 2));
        end else begin : g_none
            assign tab_a[m] = '0;
        end
    end

    logic has_operand;
    assign has_operand = (fmt == FMT_DOUBLE) || (fmt == FMT_SINGLE);

    always_comb begin
        hit   = 1'b0;
        value = '0;
        if (has_operand) begin
            if (s_reg == REG_CONST_B) begin
                hit   = 1'b1;
                value = tab_b[s_mode];
            end else if (s_reg == REG_CONST_A && s_mode[1]) begin
                hit   = 1'b1;
                value = tab_a[s_mode];
            end
        end
    end
endmodule

// File: rtl/insdec_length.sv
module insdec_length
    import insdec_pkg::*;
(
    input  fmt_e                 fmt,
    input  logic [REG_IDX_W-1:0] s_reg,
    input  logic [MODE_W-1:0]    s_mode,
    input  logic                 d_mode,
    input  logic                 bw,
    input  logic                 cg_hit,
    output logic [EXT_W-1:0]     ext,
    output logic                 mem_rd,
    output logic [INC_W-1:0]     inc
);
    localparam logic [INC_W-1:0] INC_BYTE = INC_W'(1);
    localparam logic [INC_W-1:0] INC_WORD = INC_W'(2);

    logic has_operand, src_ext, dst_ext, real_src;

    assign has_operand = (fmt == FMT_DOUBLE) || (fmt == FMT_SINGLE);
    assign real_src    = has_operand && !cg_hit;

    always_comb begin
        src_ext = 1'b0;
        if (real_src) begin
            unique case (s_mode)
                SM_IDX:          src_ext = 1'b1;
                SM_INC:          src_ext = (s_reg == REG_PC);
                SM_REG, SM_IND:  src_ext = 1'b0;
            endcase
        end
    end

    assign dst_ext = (fmt == FMT_DOUBLE) && d_mode;
    assign ext     = EXT_W'(src_ext) + EXT_W'(dst_ext);
    assign mem_rd  = real_src && (s_mode != SM_REG);

    always_comb begin
        inc = '0;
        if (real_src && s_mode == SM_INC)
            inc = (s_reg == REG_PC || !bw) ? INC_WORD : INC_BYTE;
    end
endmodule

// File: rtl/insdec_top.sv
module insdec_top
    import insdec_pkg::*;
#(
    parameter int WORD_W = INSTR_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [INSTR_W-1:0]   instr_word,
    output logic                 out_valid,
    output logic [1:0]           fmt_code,
    output logic [REG_IDX_W-1:0] src_reg,
    output logic [REG_IDX_W-1:0] dst_reg,
    output logic [MODE_W-1:0]    src_mode,
    output logic                 dst_mode,
    output logic                 byte_op,
    output logic [EXT_W-1:0]     ext_words,
    output logic                 cg_hit,
    output logic [WORD_W-1:0]    cg_value,
    output logic                 src_mem_rd,
    output logic [INC_W-1:0]     post_inc
);
    fmt_e                 c_fmt;
    logic [REG_IDX_W-1:0] c_sreg, c_dreg;
    logic [MODE_W-1:0]    c_smode;
    logic                 c_dmode, c_bw, c_hit, c_rd;
    logic [WORD_W-1:0]    c_val;
    logic [EXT_W-1:0]     c_ext;
    logic [INC_W-1:0]     c_inc;

    insdec_classify u_cls (
        .instr  (instr_word),
        .fmt    (c_fmt),
        .s_reg  (c_sreg),
        .d_reg  (c_dreg),
        .s_mode (c_smode),
        .d_mode (c_dmode),
        .bw     (c_bw)
    );

    insdec_constgen #(.WORD_W(WORD_W)) u_cg (
        .fmt    (c_fmt),
        .s_reg  (c_sreg),
        .s_mode (c_smode),
        .hit    (c_hit),
        .value  (c_val)
    );

    insdec_length u_len (
        .fmt    (c_fmt),
        .s_reg  (c_sreg),
        .s_mode (c_smode),
        .d_mode (c_dmode),
        .bw     (c_bw),
        .cg_hit (c_hit),
        .ext    (c_ext),
        .mem_rd (c_rd),
        .inc    (c_inc)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            fmt_code   <= FMT_ILLEGAL;
            src_reg    <= '0;
            dst_reg    <= '0;
            src_mode   <= '0;
            dst_mode   <= 1'b0;
            byte_op    <= 1'b0;
            ext_words  <= '0;
            cg_hit     <= 1'b0;
            cg_value   <= '0;
            src_mem_rd <= 1'b0;
            post_inc   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                fmt_code   <= c_fmt;
                src_reg    <= c_sreg;
                dst_reg    <= c_dreg;
                src_mode   <= c_smode;
                dst_mode   <= c_dmode;
                byte_op    <= c_bw;
                ext_words  <= c_ext;
                cg_hit     <= c_hit;
                cg_value   <= c_val;
                src_mem_rd <= c_rd;
                post_inc   <= c_inc;
            end
        end
    end

    p_valid_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_drops_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(src_reg) && $stable(ext_words) && $stable(cg_value)));
    p_jump_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_code == FMT_JUMP) |-> (ext_words == '0 && !cg_hit && !src_mem_rd));
    p_const_no_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cg_hit |-> !src_mem_rd);
    p_zero_const_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cg_hit && src_reg == REG_CONST_B && src_mode == SM_REG) |-> (cg_value == '0));
    p_r2_const_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cg_hit && src_reg == REG_CONST_A) |-> src_mode[1]);
    p_inc_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (post_inc != '0) |-> (src_mode == SM_INC && !cg_hit));
    p_two_ext_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_words == EXT_W'(2)) |-> (fmt_code == FMT_DOUBLE && dst_mode));
endmodule

// File: tb/insdec_top_test.sv
`timescale 1ns/1ps
module insdec_top_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [15:0] instr_word;
    logic        out_valid;
    logic [1:0]  fmt_code;
    logic [3:0]  src_reg, dst_reg;
    logic [1:0]  src_mode;
    logic        dst_mode, byte_op;
    logic [1:0]  ext_words;
    logic        cg_hit;
    logic [15:0] cg_value;
    logic        src_mem_rd;
    logic [1:0]  post_inc;

    int total = 0;
    int fails = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    insdec_top uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr_word(instr_word),
        .out_valid(out_valid), .fmt_code(fmt_code), .src_reg(src_reg),
        .dst_reg(dst_reg), .src_mode(src_mode), .dst_mode(dst_mode),
        .byte_op(byte_op), .ext_words(ext_words), .cg_hit(cg_hit),
        .cg_value(cg_value), .src_mem_rd(src_mem_rd), .post_inc(post_inc)
    );

    typedef struct {
        int fmt, s, d, as, ad, b, ext, hit, val, rd, inc;
    } exp_t;

    exp_t exp_now;
    int   exp_valid;

    function automatic exp_t model(input logic [15:0] w);
        exp_t e = '{default: 0};
        bit op;
        int se;
        if (w[15:13] == 3'b001)            e.fmt = 3;
        else if (w[15:10] == 6'b000100)    e.fmt = 2;
        else if (w[15:12] >= 4)            e.fmt = 1;
        else                               e.fmt = 0;
        if (e.fmt == 1) begin
            e.s = w[11:8]; e.ad = w[7]; e.b = w[6]; e.as = w[5:4]; e.d = w[3:0];
        end else if (e.fmt == 2) begin
            e.s = w[3:0]; e.d = w[3:0]; e.b = w[6]; e.as = w[5:4];
        end
        op = (e.fmt == 1 || e.fmt == 2);
        if (op && e.s == 3) begin
            e.hit = 1;
            e.val = (e.as == 3) ? 16'hFFFF : e.as;
        end else if (op && e.s == 2 && e.as >= 2) begin
            e.hit = 1;
            e.val = (e.as == 2) ? 4 : 8;
        end
        se = 0;
        if (op && !e.hit && (e.as == 1 || (e.as == 3 && e.s == 0))) se = 1;
        e.ext = se + ((e.fmt == 1 && e.ad == 1) ? 1 : 0);
        e.rd  = (op && !e.hit && e.as != 0) ? 1 : 0;
        if (op && !e.hit && e.as == 3) e.inc = (e.s == 0 || e.b == 0) ? 2 : 1;
        return e;
    endfunction

    task automatic chk(input string tag, input string name, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, name, act, exp);
        end
    endtask

    task automatic compare_all();
        string rt, ct;
        rt = (exp_now.fmt == 1) ? "R2" : (exp_now.fmt == 2) ? "R3" : "R4";
        ct = (exp_now.s == 2) ? "R6" : "R5";
        chk("R10", "out_valid", out_valid, exp_valid);
        chk("R1", "fmt_code", fmt_code, exp_now.fmt);
        chk(rt, "src_reg", src_reg, exp_now.s);
        chk(rt, "dst_reg", dst_reg, exp_now.d);
        chk(rt, "src_mode", src_mode, exp_now.as);
        chk(rt, "dst_mode", dst_mode, exp_now.ad);
        chk(rt, "byte_op", byte_op, exp_now.b);
        chk(ct, "cg_hit", cg_hit, exp_now.hit);
        chk(ct, "cg_value", cg_value, exp_now.val);
        chk("R7", "ext_words", ext_words, exp_now.ext);
        chk("R9", "src_mem_rd", src_mem_rd, exp_now.rd);
        chk("R8", "post_inc", post_inc, exp_now.inc);
    endtask

    task automatic step(input logic v, input logic [15:0] w);
        @(negedge clk);
        in_valid   = v;
        instr_word = w;
        exp_valid  = v;
        if (v) exp_now = model(w);
        @(negedge clk);
        in_valid = 1'b0;
        compare_all();
    endtask

    logic [15:0] dir [0:29] = '{
        16'h4405, 16'h4434, 16'h4474, 16'h4035, 16'h4215, 16'h4225,
        16'h4235, 16'h4305, 16'h4315, 16'h4325, 16'h4335, 16'h4395,
        16'h4595, 16'h4092, 16'h1005, 16'h1065, 16'h1235, 16'h1230,
        16'h1283, 16'h1293, 16'h2000, 16'h3FFF, 16'h0000, 16'h1400,
        16'h0FFF, 16'hF3B2, 16'h8F3A, 16'hFFFF, 16'h4275, 16'h5205
    };

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; instr_word = '0;
        exp_now = '{default: 0}; exp_valid = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        compare_all();  // R10 reset state
        for (int i = 0; i < 30; i++) step(1'b1, dir[i]);
        step(1'b0, 16'h4035);  // R10 hold: value ignored
        begin
            logic [15:0] lf = 16'hACE1;
            for (int i = 0; i < 600; i++) begin
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                step(lf[3:0] != 4'h0, lf ^ {lf[7:0], lf[15:8]});
            end
        end
        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            total++; fails++;
            $display("FAIL R10 watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule